// File: doc/BRIEF.md
# Asynchronous Frame Slip/Repeat Detector

This block sits between a stream of received stereo audio frames and a serial output port that runs as a slave to an external left/right clock. That clock is not locked to the incoming frame rate. The block keeps a single stereo sample buffer. Each incoming frame-start strobe writes the buffer, and each active edge of the external left/right clock copies the buffer into the output registers. When the two rates drift apart, the output either skips a frame or presents the same frame twice. The block detects either case once per input frame.

Everything runs on an internal clock at OSR (default 256) times the sample rate. The external left/right clock passes through a two-flop synchronizer before edge detection. A fixed number of cycles after each frame-start, a check counts the active output edges detected since the previous check:

- zero edges means a frame was lost (a drop);
- two or more edges means a frame was output twice (a duplicate).

A re-arm window keeps an output clock that jitters around the frame boundary from producing a stream of events. A sticky flag and a one-cycle pulse report each event to the rest of the chip.

Top module: `frame_slip_det`

## Requirements
- R1: While `rstN` is low and after its release, `outL`, `outR`, `slipFlag`, `evtPulse` and `evtKind` are all 0.
- R2: `frameStart` high at a clock edge writes `sampleL`/`sampleR` into the buffer. An external clock level change that is present before clock edge n is detected as an edge in the cycle after edge n+1. If that edge is active, the buffer is copied to `outL`/`outR` at edge n+2, and the outputs hold their value otherwise.
- R3: With `lrPol`=0 the rising edge of `lrClk` is active. With `lrPol`=1 the falling edge is active.
- R4: Call the edge that captures `frameStart` edge f. A check is made in the cycle that follows edge f+CHK_DLY. It counts the active edges detected since the previous check, including one detected in the check cycle itself. The first check after reset only restarts the count.
- R5: A check that counts exactly one edge produces no event. A count of zero gives an event of kind 0 (drop). A count of two or more gives an event of kind 1 (duplicate). An event drives `evtPulse` high for exactly one cycle after the check cycle, and `evtKind` carries the kind from that cycle on.
- R6: The detector leaves reset armed, and an event disarms it. While disarmed, no check produces an event. The detector re-arms when an active edge is detected at least WIN_CYC cycles after the latest frame-start was captured.
- R7: `slipFlag` goes to 1 together with `evtPulse`, stays 1 until a cycle with `statusRead` high, and after that stays 0 until the next event.
- R8: If `statusRead` is high in the same check cycle that produces an event, `slipFlag` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at OSR times the sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe marking a new received frame |
| sampleL | input | DATA_W | Left sample of the new frame |
| sampleR | input | DATA_W | Right sample of the new frame |
| lrClk | input | 1 | External output left/right clock, asynchronous |
| lrPol | input | 1 | 0: rising edge active, 1: falling edge active |
| statusRead | input | 1 | Status read strobe that clears the sticky flag |
| outL | output | DATA_W | Left sample presented to the serial port |
| outR | output | DATA_W | Right sample presented to the serial port |
| slipFlag | output | 1 | Sticky event flag |
| evtPulse | output | 1 | One-cycle event pulse |
| evtKind | output | 1 | Kind of the latest event: 0 drop, 1 duplicate |

## Verification
The bench first targets an output clock that alternates frame by frame across the check point, giving interval counts of 2,0,2,0. A detector without a working re-arm window would pulse on every frame instead of once. It also drifts the output clock faster and slower than the frame rate, and compares the number and kind of events with a cycle-level model. A detector that swapped the kinds, mis-timed the check or never re-armed would then disagree in count or kind. Two further cases are a status read landing in the very cycle of an event, which a flag that gave the read priority would lose, and falling-edge polarity, where a detector using the wrong edge loads the output half a period early and shows the wrong frame.

// File: rtl/slipdet_pkg.sv
package slipdet_pkg;

  // Strobes from the control half to the sample datapath
  typedef struct packed {
    logic loadBuf;   // capture the incoming frame into the buffer
    logic loadOut;   // copy the buffer to the output registers
  } dpStrobe_t;

endpackage

// File: rtl/slipdet_dpath.sv
module slipdet_dpath
  import slipdet_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR
);

  logic [DATA_W-1:0] bufL, bufR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufL <= '0;
      bufR <= '0;
    end else if (strobe.loadBuf) begin
      bufL <= sampleL;
      bufR <= sampleR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outL <= '0;
      outR <= '0;
    end else if (strobe.loadOut) begin
      outL <= bufL;
      outR <= bufR;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |=> ($stable(outL) && $stable(outR)));

  // R2
  out_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |=> (outL == $past(bufL) && outR == $past(bufR)));

endmodule

// File: rtl/slipdet_ctrl.sv
module slipdet_ctrl
  import slipdet_pkg::*;
#(
  parameter int OSR     = 256,
  parameter int CHK_DLY = 4,
  parameter int WIN_CYC = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      lrClk,
  input  logic      lrPol,
  input  logic      statusRead,
  output dpStrobe_t strobe,
  output logic      slipFlag,
  output logic      evtPulse,
  output logic      evtKind
);

  localparam int PH_W = $clog2(OSR) + 2;
  localparam logic [PH_W-1:0] PH_MAX = '1;
  localparam logic [PH_W-1:0] PH_CHK = PH_W'(CHK_DLY);
  localparam logic [PH_W-1:0] PH_WIN = PH_W'(WIN_CYC);

  // two synchronizer flops plus one history flop
  logic [2:0] lrSync;
  always_ff @(posedge clk) begin
    if (!rstN) lrSync <= '0;
    else       lrSync <= {lrSync[1:0], lrClk};
  end

  logic riseSeen, fallSeen, activeEdge;
  assign riseSeen   = lrSync[1] & ~lrSync[2];
  assign fallSeen   = ~lrSync[1] & lrSync[2];
  assign activeEdge = lrPol ? fallSeen : riseSeen;

  // cycles since the latest captured frame-start, saturating
  logic [PH_W-1:0] phase;
  always_ff @(posedge clk) begin
    if (!rstN)              phase <= PH_MAX;
    else if (frameStart)    phase <= '0;
    else if (phase != PH_MAX) phase <= phase + 1'b1;
  end

  logic checkNow;
  assign checkNow = (phase == PH_CHK);

  // active edges seen since the previous check, saturating at 2
  logic [1:0] edgeCnt;
  logic [1:0] edgeTotal;
  always_comb begin
    edgeTotal = edgeCnt;
    if (activeEdge && edgeCnt != 2'd2) edgeTotal = edgeCnt + 2'd1;
  end

  logic primed, armed, eventNow;
  assign eventNow = checkNow && primed && armed && (edgeTotal != 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt <= '0;
      primed  <= 1'b0;
    end else if (checkNow) begin
      edgeCnt <= '0;
      primed  <= 1'b1;
    end else begin
      edgeCnt <= edgeTotal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              armed <= 1'b1;
    else if (eventNow)                      armed <= 1'b0;
    else if (activeEdge && phase >= PH_WIN) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPulse <= 1'b0;
      evtKind  <= 1'b0;
      slipFlag <= 1'b0;
    end else begin
      evtPulse <= eventNow;
      if (eventNow) evtKind <= (edgeTotal == 2'd2);
      if (eventNow)        slipFlag <= 1'b1;
      else if (statusRead) slipFlag <= 1'b0;
    end
  end

  assign strobe.loadBuf = frameStart;
  assign strobe.loadOut = activeEdge;

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slipFlag && !statusRead) |=> slipFlag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !checkNow) |=> !slipFlag);

  // R8
  flag_race_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && evtPulse) |-> slipFlag);

  // R5
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> slipFlag);

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);

  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> $past(checkNow));

  // R6
  hyst_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> !armed);

endmodule

// File: rtl/frame_slip_det.sv
module frame_slip_det
  import slipdet_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int OSR     = 256,
  parameter int CHK_DLY = 4,
  parameter int WIN_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic [DATA_W-1:0] sampleL,
  input  logic [DATA_W-1:0] sampleR,
  input  logic              lrClk,
  input  logic              lrPol,
  input  logic              statusRead,
  output logic [DATA_W-1:0] outL,
  output logic [DATA_W-1:0] outR,
  output logic              slipFlag,
  output logic              evtPulse,
  output logic              evtKind
);

  dpStrobe_t strobe;

  slipdet_ctrl #(.OSR(OSR), .CHK_DLY(CHK_DLY), .WIN_CYC(WIN_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lrClk(lrClk),
    .lrPol(lrPol), .statusRead(statusRead), .strobe(strobe),
    .slipFlag(slipFlag), .evtPulse(evtPulse), .evtKind(evtKind)
  );

  slipdet_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleL(sampleL), .sampleR(sampleR), .outL(outL), .outR(outR)
  );

endmodule

// File: tb/sim_frame_slip_det.sv
module sim_frame_slip_det;

  localparam int CLK_P = 10;
  localparam int FP    = 256;   // frame period in internal cycles
  localparam int CHK   = 4;
  localparam int WIN   = 16;
  localparam int FBASE = 10;
  localparam int MAXE  = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic [23:0] sampleL = '0, sampleR = '0;
  logic lrClk = 1'b0, lrPol = 1'b0, statusRead = 1'b0;
  logic [23:0] outL, outR;
  logic slipFlag, evtPulse, evtKind;

  frame_slip_det u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .sampleL(sampleL),
    .sampleR(sampleR), .lrClk(lrClk), .lrPol(lrPol), .statusRead(statusRead),
    .outL(outL), .outR(outR), .slipFlag(slipFlag), .evtPulse(evtPulse),
    .evtKind(evtKind)
  );

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0;
  int actT[MAXE];
  int nE;
  int lrHalf;
  logic [23:0] fL[MAXE], fR[MAXE];
  int obsCnt, obsKind;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int phaseAt(input int d, input int nFr);
    int p = 1023;
    for (int j = 0; j < nFr; j++)
      if (FBASE + j*FP + 1 <= d) p = d - (FBASE + j*FP + 1);
    return p;
  endfunction

  function automatic int frameAt(input int d, input int nFr);
    int r = -1;
    for (int j = 0; j < nFr; j++)
      if (FBASE + j*FP + 1 <= d) r = j;
    return r;
  endfunction

  // cycle-level reference of the check, window and kinds (R4 R5 R6)
  function automatic void modelRun(input int nFr, output int evc, output int kind);
    int armed = 1, primed = 0, cnt = 0, ei = 0;
    evc = 0; kind = 0;
    for (int k = 0; k < nFr; k++) begin
      int cc = FBASE + k*FP + 1 + CHK;
      bit armCc = 0;
      while (ei < nE && actT[ei] + 2 <= cc) begin
        int d = actT[ei] + 2;
        int ph = phaseAt(d, nFr);
        cnt++;
        if (d == cc) armCc = (ph >= WIN);
        else if (ph >= WIN) armed = 1;
        ei++;
      end
      if (primed && armed && cnt != 1) begin
        evc++; kind = (cnt >= 2); armed = 0;
      end else if (armCc) armed = 1;
      primed = 1; cnt = 0;
    end
  endfunction

  task automatic doReset(input bit pol);
    @(negedge clk);
    rstN = 1'b0; lrPol = pol; lrClk = pol; frameStart = 0; statusRead = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
  endtask

  // jit: 0 none, 1 alternate -2/+2 cycles
  task automatic runScn(input int nFr, input int lrP, input int off, input int jit,
                        input bit pol, input int readCyc, input string dreq);
    int endC = FBASE + nFr*FP + 20;
    int ep = 0;
    nE = 0; lrHalf = lrP/2;
    for (int n = 0; n < MAXE; n++) begin
      int t = off + n*lrP + ((jit == 1) ? ((n % 2 == 0) ? -2 : 2) : 0);
      if (t <= endC) begin actT[n] = t; nE = n + 1; end
    end
    for (int j = 0; j < nFr; j++) begin fL[j] = 24'($urandom); fR[j] = 24'($urandom); end
    doReset(pol);
    obsCnt = 0; obsKind = 0;
    for (int cyc = 0; cyc <= endC; cyc++) begin
      bit act = 0;
      int fi = (cyc - FBASE) / FP;
      @(posedge clk); #1;
      frameStart = (cyc >= FBASE) && ((cyc - FBASE) % FP == 0) && (fi < nFr);
      if (frameStart) begin sampleL = fL[fi]; sampleR = fR[fi]; end
      for (int n = 0; n < nE; n++)
        if (actT[n] <= cyc && cyc < actT[n] + lrHalf) act = 1;
      lrClk = act ? ~pol : pol;
      statusRead = (cyc == readCyc);
      @(negedge clk);
      if (evtPulse) begin obsCnt++; obsKind = evtKind; end
      if (ep < nE && cyc == actT[ep] + 3) begin
        int j = frameAt(actT[ep] + 2, nFr);
        logic [23:0] eL = (j < 0) ? 24'd0 : fL[j];
        logic [23:0] eR = (j < 0) ? 24'd0 : fR[j];
        chk(outL == eL && outR == eR, dreq, int'(outL), int'(eL));
        ep++;
      end
    end
    frameStart = 0; statusRead = 0;
  endtask

  initial begin
    #(CLK_P*200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int mc, mk;
    void'($urandom(1234));

    // R1 reset state
    doReset(1'b0);
    @(negedge clk);
    chk(outL == 0 && outR == 0, "R1 outputs", int'(outL), 0);
    chk(slipFlag == 0, "R1 flag", slipFlag, 0);
    chk(evtPulse == 0 && evtKind == 0, "R1 pulse", evtPulse, 0);

    // R2 locked rates, rising edges: no events, correct data
    runScn(20, FP, 100, 0, 1'b0, -1, "R2 data");
    chk(obsCnt == 0, "R5 locked no event", obsCnt, 0);

    // R3 falling edge polarity
    runScn(20, FP, 100, 0, 1'b1, -1, "R3 data falling");
    chk(obsCnt == 0, "R3 locked no event", obsCnt, 0);

    // R5 directed duplicate (output faster)
    runScn(40, 236, 128, 0, 1'b0, -1, "R2 data dup");
    modelRun(40, mc, mk);
    chk(obsCnt == mc && mc > 0, "R5 dup count", obsCnt, mc);
    chk(obsKind == 1, "R5 dup kind", obsKind, 1);
    chk(slipFlag == 1, "R7 flag after dup", slipFlag, 1);

    // R5 directed drop (output slower)
    runScn(40, 276, 128, 0, 1'b0, -1, "R2 data drop");
    modelRun(40, mc, mk);
    chk(obsCnt == mc && mc > 0, "R5 drop count", obsCnt, mc);
    chk(obsKind == 0, "R5 drop kind", obsKind, 0);

    // R6 random drift against the model, either polarity
    for (int r = 0; r < 5; r++) begin
      int dlt = 8 + int'($urandom % 13);
      int lrP = ($urandom % 2) ? FP + dlt : FP - dlt;
      int off = 20 + int'($urandom % 230);
      bit pol = 1'($urandom % 2);
      runScn(30, lrP, off, 0, pol, -1, "R2 data drift");
      modelRun(30, mc, mk);
      chk(obsCnt == mc, "R6 drift count", obsCnt, mc);
      if (mc > 0) chk(obsKind == mk, "R5 drift kind", obsKind, mk);
      chk(slipFlag == (mc > 0), "R7 drift flag", slipFlag, (mc > 0));
    end

    // R6 jitter across the check point: exactly one event; R8 read in event cycle
    runScn(20, FP, FBASE + 3, 1, 1'b0, FBASE + FP + 1 + CHK, "R2 data jitter");
    modelRun(20, mc, mk);
    chk(obsCnt == 1, "R6 jitter single event", obsCnt, 1);
    chk(mc == 1, "R6 model agrees", mc, 1);
    chk(obsKind == 0, "R5 jitter kind", obsKind, 0);
    chk(slipFlag == 1, "R8 read with event keeps flag", slipFlag, 1);

    // R7 read clears the flag
    @(posedge clk); #1; statusRead = 1;
    @(posedge clk); #1; statusRead = 0;
    @(negedge clk);
    chk(slipFlag == 0, "R7 read clears", slipFlag, 0);
    repeat (5) @(negedge clk);
    chk(slipFlag == 0, "R7 stays clear", slipFlag, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule